// File: doc/BRIEF.md
# Configurable Logic Cell

A behavioural model of one programmable logic cell, driven by a serially loaded configuration word. Two 4-input lookup tables evaluate the F and G input groups. A 3-input lookup table combines their outputs with a third internal signal. Two combinational outputs select among the table outputs. Two storage elements register or latch a chosen source. A small crossbar lets any of four general control inputs drive the cell's internal third-table input, direct data input, set/reset and clock enable.

Each storage element has its own clock polarity, its own forced value and its own choice between edge capture and transparent latching. The forced value is applied by the cell set/reset line, by the global set/reset and for as long as the configuration port is loading. The configuration is shifted in on rising edges of the cell clock while `cfg_en` is high, first bit first.

Top module: `logic_cell`

## Requirements
- R1: While `cfg_en` is high, each rising `clk` edge shifts `cfg_in` into a 62-bit word, first bit ending at bit 61. The fields are: F table [61:46], G table [45:30], H table [29:22], third-input select [21:20], data-input select [19:18], set/reset select [17:16], enable select [15:14], set/reset connected [13], enable connected [12], X select [11], Y select [10]. The XQ element takes [9:5] and the YQ element [4:0], each laid out as {source[1:0], clock invert, forced value, latch mode}.
- R2: F output is bit {f_in[3],f_in[2],f_in[1],f_in[0]} of the F table; G likewise from `g_in` and the G table.
- R3: H output is bit {H1, G output, F output} of the H table, with the F output as the least significant index bit.
- R4: `x_out` is the F output when the X select is 0 and the H output when it is 1; `y_out` is the G output or the H output in the same way.
- R5: A select value n routes `c_in[n]` to the H1, data-input, set/reset and enable signals, each through its own select field.
- R6: The source field of a storage element picks 0 = F output, 1 = G output, 2 = H output, 3 = data input.
- R7: In flip-flop mode an element captures on the rising `clk` edge when its invert bit is 0 and on the falling edge when it is 1.
- R8: With enable low an element keeps its value across its capturing edge; with the enable-connected bit 0 the element behaves as always enabled.
- R9: A high set/reset signal drives both elements to their forced values at once, regardless of clock and enable; with the set/reset-connected bit 0 the selected input has no effect.
- R10: A high `gsr` drives both elements to their forced values at once, and they stay there until their next enabled capture.
- R11: While `cfg_en` is high both elements show their forced values.
- R12: In latch mode an element follows its source while the clock, after inversion, is high and enable is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, also shifts the configuration |
| gsr | input | 1 | Global set/reset, asynchronous, active high |
| cfg_en | input | 1 | Configuration load enable |
| cfg_in | input | 1 | Serial configuration data |
| f_in | input | 4 | F table inputs |
| g_in | input | 4 | G table inputs |
| c_in | input | 4 | General control inputs |
| x_out | output | 1 | Combinational X output |
| y_out | output | 1 | Combinational Y output |
| xq | output | 1 | XQ storage element output |
| yq | output | 1 | YQ storage element output |

## Verification
The lookup paths are swept over every F, G and control combination for each third-input select, so a swapped index bit or a wrong select shows up as a pattern mismatch. The two elements run with opposite clock polarities, so a design that ignores the invert bit captures on the wrong edge and fails at the other edge. Set/reset is held high across a capturing edge, and an enable-off data change is placed at that edge. A design that lets the clock beat the asynchronous force, or that captures with enable off, therefore shows the data value. After a force is removed the elements are read before any capture, which catches a design that reverts to stale stored data. Leaving the enable and set/reset inputs unconnected while driving the selected wires to their active-looking levels catches a design that does not fall back to the defaults.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_IN   = 4;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int HLUT_IN  = 3;
  localparam int HLUT_BITS = 1 << HLUT_IN;
  localparam int CTL_N    = 4;
  localparam int CTL_SW   = $clog2(CTL_N);

  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic inv;
    logic force_val;
    logic latch;
  } store_cfg_t;

  typedef struct packed {
    logic [LUT_BITS-1:0]  f_tt;
    logic [LUT_BITS-1:0]  g_tt;
    logic [HLUT_BITS-1:0] h_tt;
    logic [CTL_SW-1:0]    h1_sel;
    logic [CTL_SW-1:0]    din_sel;
    logic [CTL_SW-1:0]    sr_sel;
    logic [CTL_SW-1:0]    en_sel;
    logic                 sr_conn;
    logic                 en_conn;
    logic                 x_sel;
    logic                 y_sel;
    store_cfg_t           xs;
    store_cfg_t           ys;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  function automatic logic ctl_pick(input logic [CTL_N-1:0] c, input logic [CTL_SW-1:0] sel);
    return c[sel];
  endfunction

  function automatic logic src_pick(input src_e s, input logic f, input logic g,
                                    input logic h, input logic din);
    case (s)
      SRC_F:   return f;
      SRC_G:   return g;
      SRC_H:   return h;
      default: return din;
    endcase
  endfunction
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int N_IN = 4,
  localparam int N_BITS = 1 << N_IN
) (
  input  logic [N_BITS-1:0] tt,
  input  logic [N_IN-1:0]   idx,
  output logic              o
);
  assign o = tt[idx];
endmodule

// File: rtl/lcell_cfg_shift.sv
module lcell_cfg_shift #(
  parameter int W = 62
) (
  input  logic         clk,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
  input  logic clk,
  input  logic arst,
  input  logic ce,
  input  logic d,
  input  logic inv,
  input  logic force_val,
  input  logic latch,
  output logic q
);
  logic ck;
  logic ff_q, ff_forced;
  logic lat_q, lat_forced;

  assign ck = clk ^ inv;

  // forced flag: set asynchronously, cleared by the first enabled capture
  always_ff @(posedge ck or posedge arst) begin
    if (arst)    ff_forced <= 1'b1;
    else if (ce) ff_forced <= 1'b0;
  end

  always_ff @(posedge ck) begin
    if (ce && !arst) ff_q <= d;
  end

  always_latch begin
    if (arst) begin
      lat_forced = 1'b1;
    end else if (ck && ce) begin
      lat_forced = 1'b0;
      lat_q      = d;
    end
  end

  assign q = latch ? (lat_forced ? force_val : lat_q)
                   : (ff_forced  ? force_val : ff_q);
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             gsr,
  input  logic             cfg_en,
  input  logic             cfg_in,
  input  logic [LUT_IN-1:0] f_in,
  input  logic [LUT_IN-1:0] g_in,
  input  logic [CTL_N-1:0] c_in,
  output logic             x_out,
  output logic             y_out,
  output logic             xq,
  output logic             yq
);
  logic [CFG_W-1:0] cfg_bits;
  cell_cfg_t        cfg;

  lcell_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk(clk), .en(cfg_en), .din(cfg_in), .q(cfg_bits)
  );
  assign cfg = cell_cfg_t'(cfg_bits);

  // control crossbar
  logic h1_int, din_int, sr_int, ce_int, arst;
  assign h1_int  = ctl_pick(c_in, cfg.h1_sel);
  assign din_int = ctl_pick(c_in, cfg.din_sel);
  assign sr_int  = cfg.sr_conn & ctl_pick(c_in, cfg.sr_sel);
  assign ce_int  = ~cfg.en_conn | ctl_pick(c_in, cfg.en_sel);
  assign arst    = sr_int | gsr | cfg_en;

  // lookup tables
  logic f_o, g_o, h_o;
  lcell_lut #(.N_IN(LUT_IN)) u_f (.tt(cfg.f_tt), .idx(f_in), .o(f_o));
  lcell_lut #(.N_IN(LUT_IN)) u_g (.tt(cfg.g_tt), .idx(g_in), .o(g_o));
  lcell_lut #(.N_IN(HLUT_IN)) u_h (.tt(cfg.h_tt), .idx({h1_int, g_o, f_o}), .o(h_o));

  assign x_out = cfg.x_sel ? h_o : f_o;
  assign y_out = cfg.y_sel ? h_o : g_o;

  // storage elements
  store_cfg_t scfg [2];
  logic       d_arr [2];
  logic       q_arr [2];
  assign scfg[0] = cfg.xs;
  assign scfg[1] = cfg.ys;

  for (genvar i = 0; i < 2; i++) begin : g_store
    assign d_arr[i] = src_pick(scfg[i].src, f_o, g_o, h_o, din_int);
    lcell_store u_st (
      .clk(clk), .arst(arst), .ce(ce_int), .d(d_arr[i]),
      .inv(scfg[i].inv), .force_val(scfg[i].force_val),
      .latch(scfg[i].latch), .q(q_arr[i])
    );
  end

  assign xq = q_arr[0];
  assign yq = q_arr[1];

  // named views for the checker
  logic d_x, fv_x, fv_y, latch_x, inv_x;
  assign d_x     = d_arr[0];
  assign fv_x    = cfg.xs.force_val;
  assign fv_y    = cfg.ys.force_val;
  assign latch_x = cfg.xs.latch;
  assign inv_x   = cfg.xs.inv;
endmodule

// File: rtl/lcell_checker.sv
module lcell_checker (
  input logic clk,
  input logic gsr,
  input logic cfg_en,
  input logic xq,
  input logic yq,
  input logic sr_int,
  input logic ce_int,
  input logic arst,
  input logic d_x,
  input logic fv_x,
  input logic fv_y,
  input logic latch_x,
  input logic inv_x
);
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (gsr)
    cfg_en |-> (xq == fv_x && yq == fv_y));

  assert_sr_force_R9: assert property (@(posedge clk) disable iff (gsr)
    sr_int |-> (xq == fv_x && yq == fv_y));

  assert_rise_capture_R7: assert property (@(posedge clk) disable iff (gsr)
    (!latch_x && !inv_x && ce_int && !arst) |=> (arst || xq == $past(d_x)));

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (gsr)
    (!latch_x && !inv_x && !ce_int && !arst) |=> (arst || $stable(xq)));

  assert_latch_open_R12: assert property (@(negedge clk) disable iff (gsr)
    (latch_x && !inv_x && ce_int && !arst) |-> xq == d_x);
endmodule

bind logic_cell lcell_checker u_chk (
  .clk(clk), .gsr(gsr), .cfg_en(cfg_en), .xq(xq), .yq(yq),
  .sr_int(sr_int), .ce_int(ce_int), .arst(arst), .d_x(d_x),
  .fv_x(fv_x), .fv_y(fv_y), .latch_x(latch_x), .inv_x(inv_x)
);

// File: tb/tb_logic_cell.sv
module tb_logic_cell;
  logic tclk = 1'b0;
  logic k = 1'b0, gsr = 1'b1, cfg_en = 1'b0, cfg_in = 1'b0;
  logic [3:0] f_in = '0, g_in = '0, c_in = '0;
  logic x_out, y_out, xq, yq;
  int checks = 0, errors = 0, cycles = 0;

  localparam logic [15:0] FT = 16'hA5C3;
  localparam logic [15:0] GT = 16'h6E19;
  localparam logic [7:0]  HT = 8'hB4;

  logic_cell dut (.clk(k), .gsr(gsr), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .f_in(f_in), .g_in(g_in), .c_in(c_in),
    .x_out(x_out), .y_out(y_out), .xq(xq), .yq(yq));

  always #2 tclk = ~tclk;

  always @(posedge tclk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [61:0] mk(
      input logic [15:0] ft, input logic [15:0] gt, input logic [7:0] ht,
      input logic [1:0] h1s, input logic [1:0] dins, input logic [1:0] srs,
      input logic [1:0] ens, input logic sru, input logic enu,
      input logic xs, input logic ys,
      input logic [1:0] xd, input logic xi, input logic xv, input logic xl,
      input logic [1:0] yd, input logic yi, input logic yv, input logic yl);
    return {ft, gt, ht, h1s, dins, srs, ens, sru, enu, xs, ys,
            xd, xi, xv, xl, yd, yi, yv, yl};
  endfunction

  function automatic logic tbit(input logic [15:0] tt, input int idx);
    return ((tt >> idx) & 16'd1) != 16'd0;
  endfunction

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  // R1: shift in first bit first, then keep loading high briefly
  task automatic load(input logic [61:0] v);
    cfg_en = 1'b1;
    for (int i = 61; i >= 0; i--) begin
      cfg_in = v[i];
      #1 k = 1'b1; #2 k = 1'b0; #1;
    end
  endtask

  task automatic load_done();
    cfg_en = 1'b0; #1;
  endtask

  task automatic kset(input logic v);
    k = v; #2;
  endtask

  initial begin
    #3 gsr = 1'b0;

    // R2 / R4 / R1: F and G tables straight to X and Y
    load(mk(FT, GT, HT, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0,
            2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
    load_done();
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i); g_in = 4'(15 - i); #1;
      chk("R2 F table on x_out (R1 layout)", x_out, tbit(FT, i));
      chk("R2 G table on y_out", y_out, tbit(GT, 15 - i));
    end

    // R3 / R4 / R5: H table with H1 routed from each control input
    for (int hs = 0; hs < 4; hs++) begin
      load(mk(FT, GT, HT, 2'(hs), 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1,
              2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      load_done();
      for (int fv = 0; fv < 16; fv++)
        for (int gv = 0; gv < 16; gv++)
          for (int cv = 0; cv < 16; cv++) begin
            logic fo, go, h1;
            int hi;
            f_in = 4'(fv); g_in = 4'(gv); c_in = 4'(cv); #1;
            fo = tbit(FT, fv); go = tbit(GT, gv); h1 = ((cv >> hs) & 1) != 0;
            hi = (h1 ? 4 : 0) + (go ? 2 : 0) + (fo ? 1 : 0);
            chk("R3 H table via x_out (R5 H1 select)", x_out, tbit({8'h00, HT}, hi));
            chk("R4 y_out takes H", y_out, tbit({8'h00, HT}, hi));
          end
    end
    f_in = '0; g_in = '0; c_in = '0;

    // Flip-flops: data C1, enable C2, set/reset C3; X rising force 0, Y falling force 1
    load(mk(FT, GT, HT, 2'd0, 2'd0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0,
            2'd3, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0));
    #1;
    chk("R11 xq forced while loading", xq, 1'b0);
    chk("R11 yq forced while loading", yq, 1'b1);
    load_done();
    c_in = 4'b0011; #1; kset(1'b1);
    chk("R7 xq captures on rising edge", xq, 1'b1);
    chk("R7 yq ignores rising edge", yq, 1'b1);
    c_in = 4'b0010; #1; kset(1'b0);
    chk("R7 yq captures on falling edge", yq, 1'b0);
    chk("R7 xq ignores falling edge", xq, 1'b1);
    c_in = 4'b0000; #1; kset(1'b1);
    chk("R8 xq holds with enable low", xq, 1'b1);
    c_in = 4'b0001; #1; kset(1'b0);
    chk("R8 yq holds with enable low", yq, 1'b0);
    c_in = 4'b0100; #1;
    chk("R9 set/reset forces xq", xq, 1'b0);
    chk("R9 set/reset forces yq", yq, 1'b1);
    c_in = 4'b0111; #1; kset(1'b1);
    chk("R9 set/reset beats rising capture", xq, 1'b0);
    c_in = 4'b0110; #1; kset(1'b0);
    chk("R9 set/reset beats falling capture", yq, 1'b1);
    c_in = 4'b0010; #1;
    chk("R9 xq stays forced after release", xq, 1'b0);
    chk("R9 yq stays forced after release", yq, 1'b1);
    c_in = 4'b0011; #1; kset(1'b1);
    c_in = 4'b0010; #1; kset(1'b0);
    chk("R7 xq recaptures 1", xq, 1'b1);
    chk("R7 yq recaptures 0", yq, 1'b0);
    gsr = 1'b1; #1;
    chk("R10 gsr forces xq", xq, 1'b0);
    chk("R10 gsr forces yq", yq, 1'b1);
    gsr = 1'b0; #1;
    chk("R10 xq forced after gsr", xq, 1'b0);
    chk("R10 yq forced after gsr", yq, 1'b1);

    // Unconnected enable and set/reset
    load(mk(FT, GT, HT, 2'd0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0,
            2'd3, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0));
    load_done();
    c_in = 4'b0101; #1; kset(1'b1);
    chk("R8 unconnected enable captures; R9 set/reset ignored", xq, 1'b1);
    c_in = 4'b0100; #1; kset(1'b0);
    chk("R9 unconnected set/reset ignored on yq", yq, 1'b0);
    chk("R9 unconnected set/reset leaves xq", xq, 1'b1);

    // Latches: X open while clk high, Y open while clk low
    load(mk(FT, GT, HT, 2'd0, 2'd0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0,
            2'd3, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1));
    load_done();
    c_in = 4'b0011; #1;
    chk("R12 yq transparent with clk low", yq, 1'b1);
    chk("R12 xq closed with clk low", xq, 1'b0);
    kset(1'b1);
    chk("R12 xq transparent with clk high", xq, 1'b1);
    c_in = 4'b0010; #1;
    chk("R12 xq follows data 0", xq, 1'b0);
    chk("R12 yq closed with clk high", yq, 1'b1);
    c_in = 4'b0011; #1;
    chk("R12 xq follows data 1", xq, 1'b1);
    c_in = 4'b0000; #1;
    chk("R12 xq holds with enable low", xq, 1'b1);
    kset(1'b0);
    c_in = 4'b0010; #1;
    chk("R12 yq follows data 0", yq, 0);
    chk("R12 xq holds once clk low", xq, 1'b1);
    c_in = 4'b0011; #1;
    chk("R12 yq follows data 1", yq, 1'b1);

    // R6: storage source select, data input on C4, H1 on C1
    for (int ds = 0; ds < 4; ds++) begin
      load(mk(FT, GT, HT, 2'd0, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0,
              2'(ds), 1'b0, 1'b0, 1'b0, 2'(ds), 1'b0, 1'b1, 1'b0));
      load_done();
      for (int p = 0; p < 8; p++) begin
        logic fo, go, ho, di, e;
        f_in = 4'((p * 5 + 2) % 16); g_in = 4'((p * 3 + 1) % 16);
        c_in = {p[1], 2'b00, p[2]}; #1;
        fo = tbit(FT, (p * 5 + 2) % 16); go = tbit(GT, (p * 3 + 1) % 16);
        ho = tbit({8'h00, HT}, (p[2] ? 4 : 0) + (go ? 2 : 0) + (fo ? 1 : 0));
        di = p[1];
        e = (ds == 0) ? fo : (ds == 1) ? go : (ds == 2) ? ho : di;
        kset(1'b1);
        chk("R6 xq source select", xq, e);
        chk("R6 yq source select", yq, e);
        kset(1'b0);
      end
    end
    f_in = '0; g_in = '0;

    // R5: data, enable and set/reset selects each on every input
    for (int s = 0; s < 4; s++) begin
      int se, ss;
      se = (s + 1) % 4; ss = (s + 2) % 4;
      load(mk(FT, GT, HT, 2'd0, 2'(s), 2'(ss), 2'(se), 1'b1, 1'b1, 1'b0, 1'b0,
              2'd3, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0));
      load_done();
      chk("R11 xq forced value after load", xq, 1'b1);
      c_in = 4'(1 << se); #1; kset(1'b1);
      chk("R5 data select captures 0", xq, 1'b0);
      kset(1'b0);
      c_in = 4'(1 << s); #1; kset(1'b1);
      chk("R5 enable select blocks capture", xq, 1'b0);
      kset(1'b0);
      c_in = 4'(1 << ss); #1;
      chk("R5 set/reset select forces", xq, 1'b1);
      c_in = '0; #1;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule